// File: doc/BRIEF.md
# Shared Cluster Centroid Unit

This block refines peak cells found by a bank of cell engines into sub-cell track parameters. Twelve engines (a parameter) share one unit. An engine with a result raises its request and holds its 3x3 window of accumulated 16-bit responses and its integer cell coordinates on its own slice of the input bus. The unit grants one requester per accepted transfer, in round-robin order. The grant is an acknowledge pulse that lasts one cycle. The unit then forms three response-weighted sums over the window.

Each of the two axes has its own pipelined restoring divider, one quotient bit per stage. A divider turns its axis sum into a signed fixed-point fraction of the total, and that fraction is added to the cell coordinate. The dividers take a new window every cycle. Results leave in acceptance order on a valid/ready output with a fixed latency. When downstream is not ready, the whole pipeline stalls and no new request is granted.

Top module: `ccom_unit`

## Requirements
- R1: During and after reset, `out_valid` is low, and `in_ack` is low while no request is high.
- R2: In any cycle, `in_ack` has at most one bit set. The set bit belongs to a requester whose `in_req` is high. A transfer happens at the clock edge that ends a cycle with `in_ack[i]` high.
- R3: Grants rotate. After a grant to requester i, the next grant goes to the first requesting index in i+1, i+2, ... taken modulo N_REQ. The first grant after reset searches from index 0.
- R4: A window holds nine values, value k at bits [16k+15:16k] of the requester's slice. Its row is k/3 and its column is k%3. The total S is the sum of all nine values. Su is the sum of (column-1) times value. Sv is the sum of (row-1) times value.
- R5: For S>0, `out_u` = cellU*2^FRAC_W + trunc(Su*2^FRAC_W/S), with truncation toward zero. `out_v` is formed the same way from cellV and Sv. Both are signed values of COORD_W+FRAC_W+2 bits, and `out_zero` is 0.
- R6: For S=0, `out_zero` is 1 and the outputs are the bare coordinates, cellU*2^FRAC_W and cellV*2^FRAC_W.
- R7: While `out_ready` stays high, a window accepted in cycle n gives `out_valid` with its result in cycle n+FRAC_W+2. A new window can be accepted every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `in_ack` stays zero. In the next cycle `out_valid` stays high and `out_u`, `out_v` and `out_zero` hold their values.
- R9: Results leave in the order their windows were accepted, none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | N_REQ | Per-engine request, held while its window is valid |
| in_ack | output | N_REQ | One-hot acknowledge; the transfer happens at the following edge |
| in_resp | input | N_REQ*9*VAL_W | Response windows, engine i at slice i of 9*VAL_W bits |
| in_cu | input | N_REQ*COORD_W | Column coordinate of each engine's peak cell |
| in_cv | input | N_REQ*COORD_W | Row coordinate of each engine's peak cell |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream accepts the result |
| out_u | output | COORD_W+FRAC_W+2 | Refined column parameter, signed fixed point |
| out_v | output | COORD_W+FRAC_W+2 | Refined row parameter, signed fixed point |
| out_zero | output | 1 | Window sum was zero; the coordinates were passed through |

## Verification
Granting a new window and stalling the output can both depend on the same cycle's `out_ready`. So can accepting a new window and emitting an older one. The bench provokes the first by letting all twelve engines request while `out_ready` toggles in a fixed pattern. In every cycle it compares `in_ack` with its own rotating-pointer prediction, which is all zeros in a stalled cycle, and checks that a stalled output holds. The second is provoked with `out_ready` held high and requests kept back to back. Each popped result is compared with a queued expectation and its arrival cycle with the fixed latency.

// File: rtl/ccom_pkg.sv
package ccom_pkg;
  localparam int WIN = 9;

  // column offset (-1, 0, +1) of window entry k
  function automatic int col_off(int k);
    return (k % 3) - 1;
  endfunction

  // row offset (-1, 0, +1) of window entry k
  function automatic int row_off(int k);
    return (k / 3) - 1;
  endfunction
endpackage

// File: rtl/ccom_rr.sv
module ccom_rr #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] win_idx;

  always_comb begin
    int idx;
    logic found;
    grant   = '0;
    win_idx = last_q;
    found   = 1'b0;
    for (int off = 1; off <= N; off++) begin
      idx = (int'(last_q) + off) % N;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        win_idx    = IW'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (advance) last_q <= win_idx;
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/ccom_div.sv
module ccom_div #(
  parameter int ACC_W = 22,
  parameter int Q_W   = 9,
  parameter int SB_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] in_mag,
  input  logic [ACC_W-1:0] in_den,
  input  logic             in_neg,
  input  logic [SB_W-1:0]  in_sb,
  output logic [Q_W-1:0]   out_q,
  output logic             out_neg,
  output logic [SB_W-1:0]  out_sb
);
  localparam int REM_W = ACC_W + Q_W + 1;

  logic [REM_W-1:0] rem_q [1:Q_W];
  logic [ACC_W-1:0] den_q [1:Q_W];
  logic [Q_W-1:0]   quo_q [1:Q_W];
  logic             neg_q [1:Q_W];
  logic [SB_W-1:0]  sb_q  [1:Q_W];

  logic [REM_W-1:0] prev_rem [1:Q_W];
  logic [ACC_W-1:0] prev_den [1:Q_W];
  logic [Q_W-1:0]   prev_quo [1:Q_W];
  logic             prev_neg [1:Q_W];
  logic [SB_W-1:0]  prev_sb  [1:Q_W];
  logic [REM_W-1:0] trial    [1:Q_W];
  logic             fits     [1:Q_W];

  always_comb begin
    for (int g = 1; g <= Q_W; g++) begin
      if (g == 1) begin
        prev_rem[g] = REM_W'(in_mag) << (Q_W - 1);
        prev_den[g] = in_den;
        prev_quo[g] = '0;
        prev_neg[g] = in_neg;
        prev_sb[g]  = in_sb;
      end else begin
        prev_rem[g] = rem_q[g-1];
        prev_den[g] = den_q[g-1];
        prev_quo[g] = quo_q[g-1];
        prev_neg[g] = neg_q[g-1];
        prev_sb[g]  = sb_q[g-1];
      end
      trial[g] = REM_W'(prev_den[g]) << (Q_W - g);
      fits[g]  = prev_rem[g] >= trial[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 1; g <= Q_W; g++) begin
        rem_q[g] <= '0; den_q[g] <= '0; quo_q[g] <= '0;
        neg_q[g] <= 1'b0; sb_q[g] <= '0;
      end
    end else if (en) begin
      for (int g = 1; g <= Q_W; g++) begin
        rem_q[g] <= fits[g] ? prev_rem[g] - trial[g] : prev_rem[g];
        quo_q[g] <= {prev_quo[g][Q_W-2:0], fits[g]};
        den_q[g] <= prev_den[g];
        neg_q[g] <= prev_neg[g];
        sb_q[g]  <= prev_sb[g];
      end
    end
  end

  assign out_q   = quo_q[Q_W];
  assign out_neg = neg_q[Q_W];
  assign out_sb  = sb_q[Q_W];

  // |numerator| never exceeds the total, so the quotient is at most one
  assert_quot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (den_q[Q_W] != '0) |-> (out_q <= Q_W'(1 << (Q_W - 1))));
endmodule

// File: rtl/ccom_unit.sv
module ccom_unit import ccom_pkg::*; #(
  parameter int N_REQ   = 12,
  parameter int VAL_W   = 16,
  parameter int COORD_W = 8,
  parameter int FRAC_W  = 8,
  parameter int ACC_W   = 22,
  localparam int P_W    = COORD_W + FRAC_W + 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_REQ-1:0]             in_req,
  output logic [N_REQ-1:0]             in_ack,
  input  logic [N_REQ*WIN*VAL_W-1:0]   in_resp,
  input  logic [N_REQ*COORD_W-1:0]     in_cu,
  input  logic [N_REQ*COORD_W-1:0]     in_cv,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [P_W-1:0]               out_u,
  output logic [P_W-1:0]               out_v,
  output logic                         out_zero
);
  localparam int Q_W   = FRAC_W + 1;
  localparam int SB_W  = COORD_W + 1;
  localparam int WIN_W = WIN * VAL_W;
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic              advance, accept;
  logic [N_REQ-1:0]  grant;
  logic [IDX_W-1:0]  sel;
  logic [WIN_W-1:0]  win;
  logic [COORD_W-1:0] cu_m, cv_m;
  logic [ACC_W-1:0]  tot_c;
  logic signed [ACC_W-1:0] su_c, sv_c;
  logic [Q_W:0]      vld_q;

  logic [ACC_W-1:0]  s0_tot;
  logic signed [ACC_W-1:0] s0_su, s0_sv;
  logic [COORD_W-1:0] s0_cu, s0_cv;
  logic              s0_zero;

  assign advance = !vld_q[Q_W] || out_ready;
  assign accept  = advance && (|in_req);
  assign in_ack  = grant & {N_REQ{advance}};

  ccom_rr #(.N(N_REQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .advance(accept), .req(in_req), .grant(grant));

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_REQ; i++) if (grant[i]) sel = IDX_W'(i);
  end

  assign win  = in_resp[int'(sel)*WIN_W +: WIN_W];
  assign cu_m = in_cu[int'(sel)*COORD_W +: COORD_W];
  assign cv_m = in_cv[int'(sel)*COORD_W +: COORD_W];

  // weighted window sums
  always_comb begin
    logic signed [ACC_W-1:0] vx;
    tot_c = '0; su_c = '0; sv_c = '0;
    for (int k = 0; k < WIN; k++) begin
      vx    = $signed(ACC_W'(win[k*VAL_W +: VAL_W]));
      tot_c = tot_c + ACC_W'(win[k*VAL_W +: VAL_W]);
      if (col_off(k) < 0) su_c = su_c - vx;
      else if (col_off(k) > 0) su_c = su_c + vx;
      if (row_off(k) < 0) sv_c = sv_c - vx;
      else if (row_off(k) > 0) sv_c = sv_c + vx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      s0_tot <= '0; s0_su <= '0; s0_sv <= '0;
      s0_cu <= '0; s0_cv <= '0; s0_zero <= 1'b0;
    end else if (advance) begin
      vld_q <= {vld_q[Q_W-1:0], accept};
      if (accept) begin
        s0_tot  <= tot_c;
        s0_su   <= su_c;
        s0_sv   <= sv_c;
        s0_cu   <= cu_m;
        s0_cv   <= cv_m;
        s0_zero <= (tot_c == '0);
      end
    end
  end

  logic signed [ACC_W-1:0] num_a [2];
  logic [SB_W-1:0]  sbi_a [2];
  logic [SB_W-1:0]  sbo_a [2];
  logic [Q_W-1:0]   q_a   [2];
  logic             neg_a [2];
  logic [P_W-1:0]   res_a [2];

  assign num_a[0] = s0_su;
  assign num_a[1] = s0_sv;
  assign sbi_a[0] = {s0_zero, s0_cu};
  assign sbi_a[1] = {s0_zero, s0_cv};

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic [ACC_W-1:0] mag;
    logic signed [P_W-1:0] base, off_mag, off;
    assign mag = num_a[a][ACC_W-1] ? ACC_W'(-num_a[a]) : ACC_W'(num_a[a]);

    ccom_div #(.ACC_W(ACC_W), .Q_W(Q_W), .SB_W(SB_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(advance),
      .in_mag(mag), .in_den(s0_tot), .in_neg(num_a[a][ACC_W-1]), .in_sb(sbi_a[a]),
      .out_q(q_a[a]), .out_neg(neg_a[a]), .out_sb(sbo_a[a]));

    assign base    = $signed({2'b00, sbo_a[a][COORD_W-1:0], {FRAC_W{1'b0}}});
    assign off_mag = $signed(P_W'(q_a[a]));
    assign off     = sbo_a[a][COORD_W] ? '0 : (neg_a[a] ? -off_mag : off_mag);
    assign res_a[a] = base + off;
  end

  assign out_valid = vld_q[Q_W];
  assign out_u     = res_a[0];
  assign out_v     = res_a[1];
  assign out_zero  = sbo_a[0][COORD_W];

  assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_u) && $stable(out_v) && $stable(out_zero)));
  assert_no_grant_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (in_ack == '0));
  assert_zero_is_bare_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_u[FRAC_W-1:0] == '0 && out_v[FRAC_W-1:0] == '0));
endmodule

// File: tb/sim_ccom_unit.sv
module sim_ccom_unit;
  localparam int N = 12, VW = 16, CW = 8, FW = 8, PW = CW + FW + 2, LAT = FW + 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] in_req = '0;
  logic [N-1:0] in_ack;
  logic [N*9*VW-1:0] in_resp = '0;
  logic [N*CW-1:0] in_cu = '0, in_cv = '0;
  logic out_valid, out_ready = 1'b1, out_zero;
  logic [PW-1:0] out_u, out_v;

  ccom_unit u0 (.clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
    .in_resp(in_resp), .in_cu(in_cu), .in_cv(in_cv), .out_valid(out_valid),
    .out_ready(out_ready), .out_u(out_u), .out_v(out_v), .out_zero(out_zero));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  int pat = 0;
  bit stall = 0;
  int rem_cnt [N];
  int seq [N];
  int ptr_m = N - 1;
  int eu[$], ev[$], ez[$], et[$];
  bit held = 0;
  logic [PW-1:0] hu, hv;
  logic hz;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int gv(int i, int s, int k);
    int h;
    h = (i * 7919 + s * 104729 + k * 31337 + 12345) * 1103515245 + 12345;
    h = (h >> 8) & 16'hFFFF;
    case (pat)
      1: return 0;
      2: return 16'hFFFF;
      3: return (k == 0) ? i + 1 : 0;
      4: return (h % 4 == 0) ? (h & 255) : 0;
      default: return h;
    endcase
  endfunction

  function automatic int gcu(int i, int s);
    return (pat == 3) ? 0 : (i * 17 + s * 5) % 256;
  endfunction
  function automatic int gcv(int i, int s);
    return (pat == 3) ? 255 : (i * 29 + s * 3 + 200) % 256;
  endfunction

  // R4 R5 R6 reference
  task automatic model(int i, int s);
    int t, su, sv, q;
    t = 0; su = 0; sv = 0;
    for (int k = 0; k < 9; k++) begin
      t  += gv(i, s, k);
      su += ((k % 3) - 1) * gv(i, s, k);
      sv += ((k / 3) - 1) * gv(i, s, k);
    end
    if (t == 0) begin
      eu.push_back(gcu(i, s) * 256); ev.push_back(gcv(i, s) * 256); ez.push_back(1);
    end else begin
      q = ((su < 0 ? -su : su) * 256) / t;
      eu.push_back(gcu(i, s) * 256 + (su < 0 ? -q : q));
      q = ((sv < 0 ? -sv : sv) * 256) / t;
      ev.push_back(gcv(i, s) * 256 + (sv < 0 ? -q : q));
      ez.push_back(0);
    end
    et.push_back(cyc);
  endtask

  task automatic step();
    logic [N-1:0] eg;
    int au, av, gidx;
    bit en_m;
    @(negedge clk);
    out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    for (int i = 0; i < N; i++) begin
      in_req[i] = rem_cnt[i] > 0;
      for (int k = 0; k < 9; k++) in_resp[(i*9+k)*VW +: VW] = VW'(gv(i, seq[i], k));
      in_cu[i*CW +: CW] = CW'(gcu(i, seq[i]));
      in_cv[i*CW +: CW] = CW'(gcv(i, seq[i]));
    end
    #1;
    if (held) chk(out_valid && out_u == hu && out_v == hv && out_zero == hz,
                  "R8 hold", int'(out_u), int'(hu));
    en_m = !(out_valid && !out_ready);
    eg = '0; gidx = -1;
    if (en_m)
      for (int off = 1; off <= N; off++)
        if (gidx < 0 && in_req[(ptr_m + off) % N]) gidx = (ptr_m + off) % N;
    if (gidx >= 0) eg[gidx] = 1'b1;
    chk(in_ack == eg, en_m ? "R3 R2 grant" : "R8 no grant", int'(in_ack), int'(eg));
    if (gidx >= 0 && in_ack == eg) begin
      model(gidx, seq[gidx]);
      seq[gidx]++; rem_cnt[gidx]--; ptr_m = gidx;
    end
    if (out_valid && out_ready) begin
      if (eu.size() == 0) chk(0, "R9 extra result", 1, 0);
      else begin
        au = $signed(out_u); av = $signed(out_v);
        chk(au == eu[0], ez[0] ? "R6 u" : "R5 u", au, eu[0]);
        chk(av == ev[0], ez[0] ? "R6 v" : "R5 v", av, ev[0]);
        chk(int'(out_zero) == ez[0], "R6 flag", int'(out_zero), ez[0]);
        if (!stall) chk(cyc - et[0] == LAT, "R7 latency", cyc - et[0], LAT);
        void'(eu.pop_front()); void'(ev.pop_front());
        void'(ez.pop_front()); void'(et.pop_front());
      end
    end
    held = out_valid && !out_ready;
    hu = out_u; hv = out_v; hz = out_zero;
  endtask

  task automatic phase(int p, bit st, logic [N-1:0] mask, int cnt);
    int busy;
    pat = p; stall = st;
    for (int i = 0; i < N; i++) rem_cnt[i] = mask[i] ? cnt : 0;
    for (int n = 0; n < 5000; n++) begin
      busy = eu.size();
      for (int i = 0; i < N; i++) busy += rem_cnt[i];
      if (busy == 0 && !out_valid) break;
      step();
    end
    chk(eu.size() == 0, "R9 drained", eu.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin rem_cnt[i] = 0; seq[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R1 valid in reset", int'(out_valid), 0);
    chk(in_ack == 0, "R1 ack in reset", int'(in_ack), 0);
    @(negedge clk); rst_n = 1; #1;
    chk(out_valid == 0, "R1 valid after reset", int'(out_valid), 0);
    phase(0, 0, 12'h020, 4);   // single engine, back to back
    phase(0, 0, 12'hFFF, 3);   // all engines rotate
    phase(1, 0, 12'h0A5, 2);   // zero windows
    phase(2, 0, 12'h801, 2);   // saturated windows
    phase(3, 0, 12'h00F, 1);   // corner peak, offsets of -1
    phase(4, 0, 12'h3C3, 3);   // sparse windows
    phase(0, 1, 12'hFFF, 4);   // backpressure while all request
    phase(4, 1, 12'h111, 3);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule